// File: doc/BRIEF.md
# RV32I Instruction Decoder (Reduced Base Set)

This block turns one 32-bit instruction word into the control and operand fields that the decode stage of a five-stage pipelined integer core hands to the execute stage. It is purely combinational. Every output is a function of the current instruction word alone, so it can sit between the fetch/decode pipeline register and the decode/execute register with no state of its own.

It recognises a trimmed base integer set. Every instruction on the SYSTEM major opcode, whatever its remaining bits, becomes one trap request. A memory-ordering fence is accepted and does nothing except let the program counter move on. Each other encoding that is not in the supported set also raises the trap flag. When the trap flag is high, the decoder clears every side-effect enable, so a faulting word can never write a register or touch memory. The decoder adds no overflow trap, because the integer operations never raise exceptions. Misaligned accesses are outside its concern: it only reports the width and signedness of each access.

Top module: `rvd_decoder`

## Requirements
- R1: The register indices are always taken from fixed bit positions, whatever the format: `rs1_idx_o` = instr[19:15], `rs2_idx_o` = instr[24:20], `rd_idx_o` = instr[11:7].
- R2: `imm_o` is the immediate, sign-extended from instr[31]. I-layout = instr[31:20]. S-layout = {instr[31:25], instr[11:7]}. B-layout = {instr[31], instr[7], instr[30:25], instr[11:8], 0}. U-layout = {instr[31:12], 12 zeros}. J-layout = {instr[31], instr[19:12], instr[20], instr[30:21], 0}. Immediate shifts give instead the zero-extended instr[24:20]. Register-register operations, the fence and SYSTEM words give 0.
- R3: The major opcodes are: load 0000011, fence 0001111, op-imm 0010011, auipc 0010111, store 0100011, op 0110011, lui 0110111, branch 1100011, jalr 1100111, jal 1101111, system 1110011. For op and op-imm, `alu_op_o` follows funct3 (instr[14:12]) with the codes ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9. funct7 bit 5 (instr[30]) selects SUB in op only, and selects SRA/SRAI in both. Every other instruction reports ADD.
- R4: A branch (funct3 000, 001, 100, 101, 110, 111) sets `branch_o`, passes funct3 on `br_cond_o`, uses the B immediate and does not write a register. Branch funct3 010 and 011 trap.
- R5: JAL sets `jump_o`, takes the J immediate and selects the PC as operand A (code 1). JALR (funct3 000 only) sets `jump_o` and `jump_reg_o` and takes the I immediate with operand A from the register (code 0). Both write rd. JALR with any other funct3 traps.
- R6: The loads accepted are funct3 010 (word), 001 (half, signed), 101 (half, unsigned) and 100 (byte, unsigned). Each sets `mem_rd_o` and reports `mem_size_o` (0 byte, 1 half, 2 word) and `mem_unsigned_o`. Load funct3 000, 011, 110 and 111 trap.
- R7: Stores with funct3 000 (byte), 001 (half) and 010 (word) set `mem_wr_o` with the matching `mem_size_o`, use the S immediate and write no register. Any other store funct3 traps.
- R8: `rf_we_o` is 0 whenever rd is 0, so ADDI x0,x0,0 decodes as a non-trapping no-op.
- R9: A fence (funct3 000) raises no trap and asserts none of `rf_we_o`, `mem_rd_o`, `mem_wr_o`, `branch_o` and `jump_o`.
- R10: Any word whose opcode is SYSTEM raises `trap_o`, whatever its other bits.
- R11: An unknown opcode, or a funct3/funct7 pair outside the supported set, raises `trap_o`. Whenever `trap_o` is high, `rf_we_o`, `mem_rd_o`, `mem_wr_o`, `branch_o` and `jump_o` are all 0.
- R12: `opa_sel_o` selects operand A: 0 register, 1 PC (auipc, jal), 2 zero (lui). `opb_imm_o` is 1 for every instruction except op and branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| rd_idx_o | output | 5 | Destination register index |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| opa_sel_o | output | 2 | Operand A source: 0 register, 1 PC, 2 zero |
| opb_imm_o | output | 1 | Operand B is the immediate |
| branch_o | output | 1 | Conditional branch |
| br_cond_o | output | 3 | Branch condition (funct3) |
| jump_o | output | 1 | Unconditional jump |
| jump_reg_o | output | 1 | Jump target is register-relative |
| mem_rd_o | output | 1 | Load |
| mem_wr_o | output | 1 | Store |
| mem_size_o | output | 2 | Access width: 0 byte, 1 half, 2 word |
| mem_unsigned_o | output | 1 | Load is zero-extended |
| rf_we_o | output | 1 | Register write enable |
| trap_o | output | 1 | Trap request (SYSTEM or illegal) |

## Verification
No register lies between `instr_i` and any output, so every result is due in the same cycle as the word that produces it, zero clock edges later. The bench changes `instr_i` on a falling clock edge and reads every output 2 ns later, while the word is still stable and before the next rising edge. Expected values come from the bench's own instruction encoders: each test packs a chosen immediate into its format's bit layout and expects the plain sign-extended value back.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  localparam int XLEN    = 32;
  localparam int IDX_W   = 5;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int SHAMT_W = IDX_W;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLL  = 4'd2,
    ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_OR   = 4'd8,
    ALU_AND  = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {
    IMK_NONE,
    IMK_I,
    IMK_S,
    IMK_B,
    IMK_U,
    IMK_J,
    IMK_SHAMT
  } imm_kind_e;

  typedef enum logic [1:0] {
    OPA_REG  = 2'd0,
    OPA_PC   = 2'd1,
    OPA_ZERO = 2'd2
  } opa_sel_e;

  typedef enum logic [1:0] {
    MSZ_BYTE = 2'd0,
    MSZ_HALF = 2'd1,
    MSZ_WORD = 2'd2
  } mem_size_e;

endpackage

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
  import rvd_pkg::*;
(
  input  logic [XLEN-1:7] body_i,
  input  imm_kind_e       kind_i,
  output logic [XLEN-1:0] imm_o
);

  logic sgn;
  assign sgn = body_i[XLEN-1];

  always_comb begin
    imm_o = '0;
    unique case (kind_i)
      IMK_I:     imm_o = {{20{sgn}}, body_i[31:20]};
      IMK_S:     imm_o = {{20{sgn}}, body_i[31:25], body_i[11:7]};
      IMK_B:     imm_o = {{19{sgn}}, sgn, body_i[7], body_i[30:25],
                          body_i[11:8], 1'b0};
      IMK_U:     imm_o = {body_i[31:12], 12'b0};
      IMK_J:     imm_o = {{11{sgn}}, sgn, body_i[19:12], body_i[20],
                          body_i[30:21], 1'b0};
      IMK_SHAMT: imm_o = {{(XLEN-SHAMT_W){1'b0}}, body_i[24:20]};
      default:   imm_o = '0;
    endcase
  end

  // R2: every extended layout carries the instruction sign in its top bit
  always_comb begin
    if (kind_i inside {IMK_I, IMK_S, IMK_B, IMK_U, IMK_J})
      assert_imm_sign_R2: assert (imm_o[XLEN-1] == body_i[XLEN-1])
        else $error("immediate sign bit lost");
  end

  // R2: branch and jump targets are always even
  always_comb begin
    if (kind_i == IMK_B || kind_i == IMK_J)
      assert_imm_even_R2: assert (imm_o[0] == 1'b0)
        else $error("odd control-transfer offset");
  end

endmodule

// File: rtl/rvd_alu_sel.sv
module rvd_alu_sel
  import rvd_pkg::*;
(
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  input  logic            reg_form_i,
  output alu_op_e         op_o,
  output logic            ok_o
);

  logic f7_base, f7_alt;
  assign f7_base = (funct7_i == F7_BASE);
  assign f7_alt  = (funct7_i == F7_ALT);

  always_comb begin
    op_o = ALU_ADD;
    ok_o = 1'b0;
    unique case (funct3_i)
      3'b000: begin
        op_o = (reg_form_i && f7_alt) ? ALU_SUB : ALU_ADD;
        ok_o = reg_form_i ? (f7_base || f7_alt) : 1'b1;
      end
      3'b001: begin
        op_o = ALU_SLL;
        ok_o = f7_base;
      end
      3'b010: begin
        op_o = ALU_SLT;
        ok_o = reg_form_i ? f7_base : 1'b1;
      end
      3'b011: begin
        op_o = ALU_SLTU;
        ok_o = reg_form_i ? f7_base : 1'b1;
      end
      3'b100: begin
        op_o = ALU_XOR;
        ok_o = reg_form_i ? f7_base : 1'b1;
      end
      3'b101: begin
        op_o = funct7_i[5] ? ALU_SRA : ALU_SRL;
        ok_o = f7_base || f7_alt;
      end
      3'b110: begin
        op_o = ALU_OR;
        ok_o = reg_form_i ? f7_base : 1'b1;
      end
      default: begin
        op_o = ALU_AND;
        ok_o = reg_form_i ? f7_base : 1'b1;
      end
    endcase
  end

  // R3: subtraction only ever comes from the register-register form
  always_comb begin
    assert_sub_regonly_R3: assert (!(op_o == ALU_SUB && !reg_form_i))
      else $error("SUB decoded from immediate form");
  end

endmodule

// File: rtl/rvd_ctrl.sv
module rvd_ctrl
  import rvd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [F3_W-1:0]  funct3_i,
  input  logic             rd_zero_i,
  input  logic             arith_ok_i,
  output imm_kind_e        kind_o,
  output logic             use_sel_o,
  output logic             reg_form_o,
  output opa_sel_e         opa_o,
  output logic             opb_imm_o,
  output logic             branch_o,
  output logic             jump_o,
  output logic             jump_reg_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output mem_size_e        size_o,
  output logic             unsigned_o,
  output logic             rf_we_o,
  output logic             trap_o
);

  logic raw_branch, raw_jump, raw_jreg, raw_rd, raw_wr, raw_we;
  logic illegal, sys_trap;

  always_comb begin
    kind_o     = IMK_NONE;
    use_sel_o  = 1'b0;
    reg_form_o = 1'b0;
    opa_o      = OPA_REG;
    opb_imm_o  = 1'b1;
    raw_branch = 1'b0;
    raw_jump   = 1'b0;
    raw_jreg   = 1'b0;
    raw_rd     = 1'b0;
    raw_wr     = 1'b0;
    raw_we     = 1'b0;
    size_o     = MSZ_WORD;
    unsigned_o = 1'b0;
    illegal    = 1'b0;
    sys_trap   = 1'b0;
    unique case (opcode_i)
      OPC_LUI: begin
        kind_o = IMK_U;
        opa_o  = OPA_ZERO;
        raw_we = 1'b1;
      end
      OPC_AUIPC: begin
        kind_o = IMK_U;
        opa_o  = OPA_PC;
        raw_we = 1'b1;
      end
      OPC_JAL: begin
        kind_o   = IMK_J;
        opa_o    = OPA_PC;
        raw_jump = 1'b1;
        raw_we   = 1'b1;
      end
      OPC_JALR: begin
        kind_o   = IMK_I;
        raw_jump = 1'b1;
        raw_jreg = 1'b1;
        raw_we   = 1'b1;
        illegal  = (funct3_i != 3'b000);
      end
      OPC_BRANCH: begin
        kind_o     = IMK_B;
        opb_imm_o  = 1'b0;
        raw_branch = 1'b1;
        illegal    = (funct3_i[2:1] == 2'b01);
      end
      OPC_LOAD: begin
        kind_o     = IMK_I;
        raw_rd     = 1'b1;
        raw_we     = 1'b1;
        unsigned_o = funct3_i[2];
        unique case (funct3_i)
          3'b010:  size_o = MSZ_WORD;
          3'b001:  size_o = MSZ_HALF;
          3'b101:  size_o = MSZ_HALF;
          3'b100:  size_o = MSZ_BYTE;
          default: illegal = 1'b1;
        endcase
      end
      OPC_STORE: begin
        kind_o = IMK_S;
        raw_wr = 1'b1;
        unique case (funct3_i)
          3'b000:  size_o = MSZ_BYTE;
          3'b001:  size_o = MSZ_HALF;
          3'b010:  size_o = MSZ_WORD;
          default: illegal = 1'b1;
        endcase
      end
      OPC_OPIMM: begin
        kind_o    = (funct3_i[1:0] == 2'b01) ? IMK_SHAMT : IMK_I;
        use_sel_o = 1'b1;
        raw_we    = 1'b1;
        illegal   = !arith_ok_i;
      end
      OPC_OP: begin
        use_sel_o  = 1'b1;
        reg_form_o = 1'b1;
        opb_imm_o  = 1'b0;
        raw_we     = 1'b1;
        illegal    = !arith_ok_i;
      end
      OPC_FENCE: begin
        illegal = (funct3_i != 3'b000);
      end
      OPC_SYSTEM: begin
        sys_trap = 1'b1;
      end
      default: begin
        illegal = 1'b1;
      end
    endcase
  end

  assign trap_o     = illegal | sys_trap;
  assign branch_o   = raw_branch & ~trap_o;
  assign jump_o     = raw_jump & ~trap_o;
  assign jump_reg_o = raw_jreg & ~trap_o;
  assign mem_rd_o   = raw_rd & ~trap_o;
  assign mem_wr_o   = raw_wr & ~trap_o;
  assign rf_we_o    = raw_we & ~trap_o & ~rd_zero_i;

  // R6, R7: at most one kind of side effect or control transfer per word
  always_comb begin
    assert_one_effect_R6: assert ($onehot0({mem_rd_o, mem_wr_o, branch_o, jump_o}))
      else $error("conflicting side effects");
  end

  // R10: the system opcode always traps
  always_comb begin
    if (opcode_i == OPC_SYSTEM)
      assert_system_traps_R10: assert (trap_o)
        else $error("system word did not trap");
  end

endmodule

// File: rtl/rvd_decoder.sv
module rvd_decoder
  import rvd_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs1_idx_o,
  output logic [4:0]  rs2_idx_o,
  output logic [4:0]  rd_idx_o,
  output logic [31:0] imm_o,
  output logic [3:0]  alu_op_o,
  output logic [1:0]  opa_sel_o,
  output logic        opb_imm_o,
  output logic        branch_o,
  output logic [2:0]  br_cond_o,
  output logic        jump_o,
  output logic        jump_reg_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [1:0]  mem_size_o,
  output logic        mem_unsigned_o,
  output logic        rf_we_o,
  output logic        trap_o
);

  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  logic [F7_W-1:0]  funct7;

  assign opcode    = instr_i[6:0];
  assign funct3    = instr_i[14:12];
  assign funct7    = instr_i[31:25];
  assign rs1_idx_o = instr_i[19:15];
  assign rs2_idx_o = instr_i[24:20];
  assign rd_idx_o  = instr_i[11:7];
  assign br_cond_o = funct3;

  imm_kind_e kind;
  alu_op_e   sel_op;
  opa_sel_e  opa;
  mem_size_e msize;
  logic      arith_ok, use_sel, reg_form;

  rvd_alu_sel u_alu_sel (
    .funct3_i   (funct3),
    .funct7_i   (funct7),
    .reg_form_i (reg_form),
    .op_o       (sel_op),
    .ok_o       (arith_ok)
  );

  rvd_ctrl u_ctrl (
    .opcode_i   (opcode),
    .funct3_i   (funct3),
    .rd_zero_i  (rd_idx_o == '0),
    .arith_ok_i (arith_ok),
    .kind_o     (kind),
    .use_sel_o  (use_sel),
    .reg_form_o (reg_form),
    .opa_o      (opa),
    .opb_imm_o  (opb_imm_o),
    .branch_o   (branch_o),
    .jump_o     (jump_o),
    .jump_reg_o (jump_reg_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .size_o     (msize),
    .unsigned_o (mem_unsigned_o),
    .rf_we_o    (rf_we_o),
    .trap_o     (trap_o)
  );

  rvd_imm_gen u_imm (
    .body_i (instr_i[31:7]),
    .kind_i (kind),
    .imm_o  (imm_o)
  );

  assign alu_op_o   = use_sel ? sel_op : ALU_ADD;
  assign opa_sel_o  = opa;
  assign mem_size_o = msize;

  // R11: a trapping word has no architectural side effect
  always_comb begin
    if (trap_o)
      assert_trap_quiet_R11: assert (!rf_we_o && !mem_rd_o && !mem_wr_o
                                     && !branch_o && !jump_o)
        else $error("trap with live enable");
  end

  // R8: register zero is never written
  always_comb begin
    if (rd_idx_o == 5'd0)
      assert_x0_nowrite_R8: assert (!rf_we_o)
        else $error("write enable for x0");
  end

endmodule

// File: tb/tb_rvd_decoder.sv
module tb_rvd_decoder;

  logic        clk;
  logic [31:0] instr;
  logic [4:0]  rs1, rs2, rd;
  logic [31:0] imm;
  logic [3:0]  alu_op;
  logic [1:0]  opa, msize;
  logic        opb_imm, br, jmp, jreg, mrd, mwr, muns, we, trap;
  logic [2:0]  bcond;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rvd_decoder dut (
    .instr_i(instr), .rs1_idx_o(rs1), .rs2_idx_o(rs2), .rd_idx_o(rd),
    .imm_o(imm), .alu_op_o(alu_op), .opa_sel_o(opa), .opb_imm_o(opb_imm),
    .branch_o(br), .br_cond_o(bcond), .jump_o(jmp), .jump_reg_o(jreg),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_size_o(msize),
    .mem_unsigned_o(muns), .rf_we_o(we), .trap_o(trap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {f7, s2, s1, f3, d, op};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] s1,
      input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {im, s1, f3, d, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3);
    return {im[11:5], s2, s1, f3, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] s2,
      input logic [4:0] s1, input logic [2:0] f3);
    return {im[12], im[10:5], s2, s1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] im, input logic [4:0] d);
    return {im[20], im[10:1], im[11], im[19:12], d, 7'b1101111};
  endfunction

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "rf_we", {31'b0, we}, 0);
    chk(req, "mem_rd", {31'b0, mrd}, 0);
    chk(req, "mem_wr", {31'b0, mwr}, 0);
    chk(req, "branch", {31'b0, br}, 0);
    chk(req, "jump", {31'b0, jmp}, 0);
  endtask

  task automatic t_idle;
    apply(32'h0);
    chk("R11", "trap on zero word", {31'b0, trap}, 1);
    chk_quiet("R11");
  endtask

  task automatic t_fields;
    apply(enc_r(7'h00, 5'd21, 5'd10, 3'b000, 5'd31, 7'b0110011));
    chk("R1", "rs1", {27'b0, rs1}, 10);
    chk("R1", "rs2", {27'b0, rs2}, 21);
    chk("R1", "rd", {27'b0, rd}, 31);
    apply(enc_s(12'h800, 5'd3, 5'd17, 3'b010));
    chk("R1", "store rs1", {27'b0, rs1}, 17);
    chk("R1", "store rs2", {27'b0, rs2}, 3);
  endtask

  task automatic t_op;
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd5, 7'b0110011));
    chk("R3", "ADD op", {28'b0, alu_op}, 0);
    chk("R12", "OP opb_imm", {31'b0, opb_imm}, 0);
    chk("R2", "OP imm", imm, 0);
    chk("R3", "ADD we", {31'b0, we}, 1);
    apply(enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd5, 7'b0110011));
    chk("R3", "SUB op", {28'b0, alu_op}, 1);
    apply(enc_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd5, 7'b0110011));
    chk("R3", "SRA op", {28'b0, alu_op}, 7);
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'b011, 5'd5, 7'b0110011));
    chk("R3", "SLTU op", {28'b0, alu_op}, 4);
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd5, 7'b0110011));
    chk("R3", "AND op", {28'b0, alu_op}, 9);
    apply(enc_r(7'h20, 5'd2, 5'd1, 3'b111, 5'd5, 7'b0110011));
    chk("R11", "AND alt funct7 trap", {31'b0, trap}, 1);
    chk("R11", "AND alt funct7 we", {31'b0, we}, 0);
  endtask

  task automatic t_opimm;
    apply(enc_i(12'hF85, 5'd4, 3'b000, 5'd6, 7'b0010011));
    chk("R2", "ADDI imm", imm, 32'hFFFFFF85);
    chk("R3", "ADDI op", {28'b0, alu_op}, 0);
    chk("R12", "ADDI opb_imm", {31'b0, opb_imm}, 1);
    apply(enc_i(12'h407, 5'd4, 3'b101, 5'd6, 7'b0010011));
    chk("R3", "SRAI op", {28'b0, alu_op}, 7);
    chk("R2", "SRAI shamt", imm, 7);
    apply(enc_i(12'h800, 5'd4, 3'b000, 5'd6, 7'b0010011));
    chk("R3", "ADDI with bit30 still ADD", {28'b0, alu_op}, 0);
    apply(enc_i(12'h41F, 5'd4, 3'b001, 5'd6, 7'b0010011));
    chk("R11", "SLLI alt funct7 trap", {31'b0, trap}, 1);
  endtask

  task automatic t_upper;
    apply({20'hABCDE, 5'd7, 7'b0110111});
    chk("R2", "LUI imm", imm, 32'hABCDE000);
    chk("R12", "LUI opa zero", {30'b0, opa}, 2);
    chk("R12", "LUI we", {31'b0, we}, 1);
    apply({20'h00123, 5'd7, 7'b0010111});
    chk("R2", "AUIPC imm", imm, 32'h00123000);
    chk("R12", "AUIPC opa pc", {30'b0, opa}, 1);
  endtask

  task automatic t_jumps;
    apply(enc_j(21'h1FF804, 5'd1));
    chk("R5", "JAL jump", {31'b0, jmp}, 1);
    chk("R5", "JAL jreg", {31'b0, jreg}, 0);
    chk("R2", "JAL imm", imm, 32'hFFFFF804);
    chk("R5", "JAL opa pc", {30'b0, opa}, 1);
    chk("R5", "JAL we", {31'b0, we}, 1);
    apply(enc_i(12'h010, 5'd1, 3'b000, 5'd5, 7'b1100111));
    chk("R5", "JALR jreg", {31'b0, jreg}, 1);
    chk("R5", "JALR imm", imm, 16);
    chk("R5", "JALR opa reg", {30'b0, opa}, 0);
    apply(enc_i(12'h010, 5'd1, 3'b001, 5'd5, 7'b1100111));
    chk("R5", "JALR bad funct3 trap", {31'b0, trap}, 1);
    chk_quiet("R11");
  endtask

  task automatic t_branch;
    apply(enc_b(13'h1FF0, 5'd9, 5'd8, 3'b110));
    chk("R4", "BLTU branch", {31'b0, br}, 1);
    chk("R4", "BLTU cond", {29'b0, bcond}, 6);
    chk("R4", "BLTU imm", imm, 32'hFFFFFFF0);
    chk("R4", "BLTU we", {31'b0, we}, 0);
    chk("R12", "branch opb_imm", {31'b0, opb_imm}, 0);
    apply(enc_b(13'h0802, 5'd9, 5'd8, 3'b000));
    chk("R2", "BEQ imm bit11", imm, 32'h00000802);
    apply(enc_b(13'h0010, 5'd9, 5'd8, 3'b010));
    chk("R4", "branch funct3 010 trap", {31'b0, trap}, 1);
    chk("R4", "branch funct3 010 no branch", {31'b0, br}, 0);
  endtask

  task automatic t_loads;
    apply(enc_i(12'hFFC, 5'd2, 3'b001, 5'd12, 7'b0000011));
    chk("R6", "LH rd", {31'b0, mrd}, 1);
    chk("R6", "LH size", {30'b0, msize}, 1);
    chk("R6", "LH signed", {31'b0, muns}, 0);
    chk("R6", "LH imm", imm, 32'hFFFFFFFC);
    apply(enc_i(12'h003, 5'd2, 3'b100, 5'd12, 7'b0000011));
    chk("R6", "LBU size", {30'b0, msize}, 0);
    chk("R6", "LBU unsigned", {31'b0, muns}, 1);
    apply(enc_i(12'h003, 5'd2, 3'b010, 5'd12, 7'b0000011));
    chk("R6", "LW size", {30'b0, msize}, 2);
    apply(enc_i(12'h003, 5'd2, 3'b000, 5'd12, 7'b0000011));
    chk("R6", "LB trap", {31'b0, trap}, 1);
    chk("R6", "LB no read", {31'b0, mrd}, 0);
  endtask

  task automatic t_stores;
    apply(enc_s(12'h9A5, 5'd6, 5'd2, 3'b000));
    chk("R7", "SB wr", {31'b0, mwr}, 1);
    chk("R7", "SB size", {30'b0, msize}, 0);
    chk("R7", "SB imm", imm, 32'hFFFFF9A5);
    chk("R7", "SB we", {31'b0, we}, 0);
    apply(enc_s(12'h040, 5'd6, 5'd2, 3'b010));
    chk("R7", "SW size", {30'b0, msize}, 2);
    apply(enc_s(12'h040, 5'd6, 5'd2, 3'b011));
    chk("R7", "store funct3 011 trap", {31'b0, trap}, 1);
    chk("R7", "store funct3 011 no write", {31'b0, mwr}, 0);
  endtask

  task automatic t_x0;
    apply(32'h00000013);
    chk("R8", "NOP we", {31'b0, we}, 0);
    chk("R8", "NOP trap", {31'b0, trap}, 0);
    apply({20'h12345, 5'd0, 7'b0110111});
    chk("R8", "LUI x0 we", {31'b0, we}, 0);
  endtask

  task automatic t_fence;
    apply(32'h0FF0000F);
    chk("R9", "FENCE trap", {31'b0, trap}, 0);
    chk_quiet("R9");
  endtask

  task automatic t_system;
    apply(32'h00000073);
    chk("R10", "ECALL trap", {31'b0, trap}, 1);
    apply(32'h00100073);
    chk("R10", "EBREAK trap", {31'b0, trap}, 1);
    apply(32'h30002573);
    chk("R10", "other system trap", {31'b0, trap}, 1);
    chk_quiet("R10");
  endtask

  task automatic t_illegal;
    apply(32'hFFFFFFFF);
    chk("R11", "unknown opcode trap", {31'b0, trap}, 1);
    chk_quiet("R11");
    apply(32'h0000100F);
    chk("R11", "fence funct3 001 trap", {31'b0, trap}, 1);
  endtask

  initial begin
    instr = 32'h0;
    t_idle();
    t_fields();
    t_op();
    t_opimm();
    t_upper();
    t_jumps();
    t_branch();
    t_loads();
    t_stores();
    t_x0();
    t_fence();
    t_system();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule